// File: doc/BRIEF.md
# Priority-Level Vectored Interrupt Controller

This block gathers thirteen level-sensitive interrupt requests, numbered 1 to 13, and presents one of them to a processor as a 3-bit interrupt level and an 8-bit vector number. Every request is copied into a pending register on each clock. A mask register can exclude any source. Each source has its own control byte. That byte sets its level, its priority within the level, and whether it is autovectored.

On every cycle the arbiter compares the 5-bit code {level, priority} of all pending, unmasked sources. The largest code wins, and on a tie the lower source number wins. A winner whose code is below 4 (level 0) is not presented. If the winner's autovector bit is set, the vector is 24 plus its level. Otherwise the vector comes from one of three programmable vector registers, which serve the watchdog source (8) and the two serial-port sources (12 and 13). Any other source gets vector 0x0F. Software programs the block through a simple byte-offset register port with a combinational read path.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset the mask reads 0x3FFE. The control bytes of sources 1..7 read 0x04,0x08,0x0C,0x10,0x14,0x18,0x1C. Source 8 reads 0x1C, sources 9..11 read 0x80 and sources 12..13 read 0x00. All three vector registers read 0x0F. Level and vector outputs are 0.
- R2: Bit i of the pending register (offset 0x3A, bits 13:1, bit 0 reads 0) equals request input i as sampled on the previous clock. A write to 0x3A has no effect.
- R3: A source whose mask bit is 1 (mask at offset 0x36, bit i for source i) takes no part in arbitration.
- R4: The winner is the active source with the largest control[4:0], where control[4:2] is the level and control[1:0] is the priority within that level.
- R5: When two active sources have equal control[4:0], the lower-numbered source wins.
- R6: When the winning control[4:0] is below 4, or no source is active, the level output and the vector output are both 0.
- R7: When control bit 7 of the winner is set, the vector is 24 plus the winner's level, and the level output is control[4:2].
- R8: When control bit 7 of the winner is clear, source 8 uses the watchdog vector register (0x42), source 12 uses the first serial vector register (0x170), source 13 uses the second serial vector register (0x1B0), and all other sources use 0x0F.
- R9: The level and vector outputs are registered. A request change appears at the outputs on the second clock edge. A write to the mask or a control byte appears on the first clock edge after the write edge.
- R10: Control bytes for sources 1..13 sit at offsets 0x14..0x20 and read back what was written. Reads of unmapped offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 13 | Level request per source, bit i is source i (bits 13:1) |
| bus_addr | input | 9 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 16 | Write data (byte registers use bits 7:0) |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| irq_level | output | 3 | Interrupt level presented to the processor, 0 = none |
| irq_vec | output | 8 | Vector number presented with the level |

## Verification
Arbitration is tried with single requests, with two sources on different levels, with two sources on the same level but different priority bits, and with an exact code tie. Each case uses autovector bits chosen so that the winner shows up in the vector as well as the level. A source with code 3 and then code 4 probes the suppression threshold. Sources 8, 12 and 13 are tried with and without the autovector bit to separate the dedicated vector registers from the fixed 0x0F path. A request and a mask write are each stepped one edge at a time to pin down the output latency.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Reset value of the control byte of source s.
  function automatic logic [7:0] ctrl_reset(input int s);
    if (s >= 1 && s <= 7) return 8'(s * 4);
    else if (s == 8) return 8'h1C;
    else if (s >= 9 && s <= 11) return 8'h80;
    else return 8'h00;
  endfunction

  // Autovector number for a level.
  function automatic logic [7:0] autovec(input logic [7:0] base, input logic [2:0] lvl);
    return base + {5'd0, lvl};
  endfunction

endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 13,
  parameter int AW = 9,
  parameter int DW = 16,
  parameter int CTRL_BASE = 'h14,
  parameter int ADDR_MASK = 'h36,
  parameter int ADDR_PEND = 'h3A,
  parameter int ADDR_WDV = 'h42,
  parameter int ADDR_UV0 = 'h170,
  parameter int ADDR_UV1 = 'h1B0,
  parameter logic [DW-1:0] MASK_RST = 'h3FFE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC:1]        irq_req,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_we,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic [NSRC:1]        pend_q,
  output logic [DW-1:0]        mask_q,
  output logic [NSRC:1][7:0]   ctrl_q,
  output logic [7:0]           wdv_q,
  output logic [7:0]           uv0_q,
  output logic [7:0]           uv1_q
);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= irq_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= MASK_RST;
      wdv_q  <= 8'h0F;
      uv0_q  <= 8'h0F;
      uv1_q  <= 8'h0F;
      for (int s = 1; s <= NSRC; s++) ctrl_q[s] <= ctrl_reset(s);
    end else if (bus_we) begin
      if (bus_addr == AW'(ADDR_MASK)) mask_q <= bus_wdata;
      if (bus_addr == AW'(ADDR_WDV))  wdv_q  <= bus_wdata[7:0];
      if (bus_addr == AW'(ADDR_UV0))  uv0_q  <= bus_wdata[7:0];
      if (bus_addr == AW'(ADDR_UV1))  uv1_q  <= bus_wdata[7:0];
      for (int s = 1; s <= NSRC; s++)
        if (bus_addr == AW'(CTRL_BASE + s - 1)) ctrl_q[s] <= bus_wdata[7:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADDR_MASK)) bus_rdata = mask_q;
    if (bus_addr == AW'(ADDR_PEND)) bus_rdata[NSRC:0] = {pend_q, 1'b0};
    if (bus_addr == AW'(ADDR_WDV))  bus_rdata[7:0] = wdv_q;
    if (bus_addr == AW'(ADDR_UV0))  bus_rdata[7:0] = uv0_q;
    if (bus_addr == AW'(ADDR_UV1))  bus_rdata[7:0] = uv1_q;
    for (int s = 1; s <= NSRC; s++)
      if (bus_addr == AW'(CTRL_BASE + s - 1)) bus_rdata[7:0] = ctrl_q[s];
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC = 13,
  parameter int IW = 4,
  parameter int MIN_CODE = 4
) (
  input  logic [NSRC:1]      pend,
  input  logic [NSRC:1]      mask,
  input  logic [NSRC:1][7:0] ctrl,
  output logic               win_valid,
  output logic [IW-1:0]      win_idx,
  output logic [4:0]         win_code,
  output logic [7:0]         win_ctrl
);

  // Ascending scan, strictly-larger replacement: ties keep the lower index.
  always_comb begin
    win_idx  = '0;
    win_code = '0;
    win_ctrl = '0;
    for (int s = 1; s <= NSRC; s++) begin
      if (pend[s] && !mask[s] && (ctrl[s][4:0] > win_code)) begin
        win_idx  = IW'(s);
        win_code = ctrl[s][4:0];
        win_ctrl = ctrl[s];
      end
    end
    win_valid = (win_code >= 5'(MIN_CODE));
  end

endmodule

// File: rtl/irq_vecgen.sv
module irq_vecgen
  import irq_prio_pkg::*;
#(
  parameter int IW = 4,
  parameter int SRC_WDOG = 8,
  parameter int SRC_UART0 = 12,
  parameter int SRC_UART1 = 13,
  parameter logic [7:0] AUTOVEC_BASE = 8'd24,
  parameter logic [7:0] UNKNOWN_VEC = 8'h0F
) (
  input  logic          win_valid,
  input  logic [IW-1:0] win_idx,
  input  logic          win_auto,
  input  logic [2:0]    win_lvl,
  input  logic [7:0]    wdv,
  input  logic [7:0]    uv0,
  input  logic [7:0]    uv1,
  output logic [2:0]    nxt_level,
  output logic [7:0]    nxt_vec
);

  always_comb begin
    nxt_level = '0;
    nxt_vec   = '0;
    if (win_valid) begin
      nxt_level = win_lvl;
      if (win_auto)                       nxt_vec = autovec(AUTOVEC_BASE, win_lvl);
      else if (win_idx == IW'(SRC_WDOG))  nxt_vec = wdv;
      else if (win_idx == IW'(SRC_UART0)) nxt_vec = uv0;
      else if (win_idx == IW'(SRC_UART1)) nxt_vec = uv1;
      else                                nxt_vec = UNKNOWN_VEC;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC = 13,
  parameter int AW = 9,
  parameter int DW = 16,
  parameter logic [7:0] AUTOVEC_BASE = 8'd24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC:1]   irq_req,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [2:0]      irq_level,
  output logic [7:0]      irq_vec
);

  localparam int IW = $clog2(NSRC + 1);

  logic [NSRC:1]      pend_q;
  logic [DW-1:0]      mask_q;
  logic [NSRC:1][7:0] ctrl_q;
  logic [7:0]         wdv_q, uv0_q, uv1_q;
  logic               win_valid;
  logic [IW-1:0]      win_idx;
  logic [4:0]         win_code;
  logic [7:0]         win_ctrl;
  logic [2:0]         nxt_level;
  logic [7:0]         nxt_vec;

  irq_regs #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .irq_req(irq_req),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_q(pend_q), .mask_q(mask_q), .ctrl_q(ctrl_q),
    .wdv_q(wdv_q), .uv0_q(uv0_q), .uv1_q(uv1_q)
  );

  irq_arbiter #(.NSRC(NSRC), .IW(IW)) u_arb (
    .pend(pend_q), .mask(mask_q[NSRC:1]), .ctrl(ctrl_q),
    .win_valid(win_valid), .win_idx(win_idx), .win_code(win_code), .win_ctrl(win_ctrl)
  );

  irq_vecgen #(.IW(IW), .AUTOVEC_BASE(AUTOVEC_BASE)) u_vec (
    .win_valid(win_valid), .win_idx(win_idx),
    .win_auto(win_ctrl[7]), .win_lvl(win_ctrl[4:2]),
    .wdv(wdv_q), .uv0(uv0_q), .uv1(uv1_q),
    .nxt_level(nxt_level), .nxt_vec(nxt_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level <= '0;
      irq_vec   <= '0;
    end else begin
      irq_level <= nxt_level;
      irq_vec   <= nxt_vec;
    end
  end

endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker #(
  parameter int NSRC = 13,
  parameter int IW = 4,
  parameter int DW = 16,
  parameter logic [7:0] AUTOVEC_BASE = 8'd24
) (
  input logic               clk,
  input logic               rst,
  input logic [NSRC:1]      irq_req,
  input logic [NSRC:1]      pend_q,
  input logic [DW-1:0]      mask_q,
  input logic [NSRC:1][7:0] ctrl_q,
  input logic               win_valid,
  input logic [IW-1:0]      win_idx,
  input logic [4:0]         win_code,
  input logic [7:0]         win_ctrl,
  input logic [2:0]         irq_level,
  input logic [7:0]         irq_vec
);

  a_r2_pend_tracks_req: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pend_q == $past(irq_req));

  a_r3_winner_unmasked: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (pend_q[win_idx] && !mask_q[win_idx]));

  for (genvar s = 1; s <= NSRC; s++) begin : g_src
    a_r4_no_larger_active: assert property (@(posedge clk) disable iff (rst)
      (win_valid && pend_q[s] && !mask_q[s]) |-> ctrl_q[s][4:0] <= win_code);
    a_r5_tie_lowest: assert property (@(posedge clk) disable iff (rst)
      (win_valid && pend_q[s] && !mask_q[s] && ctrl_q[s][4:0] == win_code)
        |-> IW'(s) >= win_idx);
  end

  a_r6_idle_outputs: assert property (@(posedge clk) disable iff (rst)
    !win_valid |=> (irq_level == 3'd0 && irq_vec == 8'd0));

  a_r6_level0_vec0: assert property (@(posedge clk) disable iff (rst)
    irq_level == 3'd0 |-> irq_vec == 8'd0);

  a_r7_autovector: assert property (@(posedge clk) disable iff (rst)
    (win_valid && win_ctrl[7]) |=> irq_vec == AUTOVEC_BASE + {5'd0, irq_level});

endmodule

bind irq_prio_ctrl irq_prio_checker #(.NSRC(NSRC), .IW(IW), .DW(DW), .AUTOVEC_BASE(AUTOVEC_BASE)) u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .pend_q(pend_q), .mask_q(mask_q),
  .ctrl_q(ctrl_q), .win_valid(win_valid), .win_idx(win_idx), .win_code(win_code),
  .win_ctrl(win_ctrl), .irq_level(irq_level), .irq_vec(irq_vec)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:1] irq_req = '0;
  logic [8:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .irq_req(irq_req), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_level(irq_level), .irq_vec(irq_vec)
  );

  // All tasks are entered and left at a falling edge.
  task automatic wr(input logic [8:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk_rd(input logic [8:0] a, input logic [15:0] exp, input string tag);
    bus_addr = a;
    #1;
    n_chk++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: read 0x%0h got 0x%0h expected 0x%0h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_out(input logic [2:0] lvl, input logic [7:0] vec, input string tag);
    n_chk++;
    if (irq_level !== lvl || irq_vec !== vec) begin
      n_bad++;
      $display("FAIL %s: level/vec got %0d/0x%0h expected %0d/0x%0h", tag, irq_level, irq_vec, lvl, vec);
    end
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  function automatic logic [13:1] one(input int s);
    logic [13:1] v = '0;
    v[s] = 1'b1;
    return v;
  endfunction

  task automatic t_reset();
    logic [7:0] rv [1:13] = '{8'h04,8'h08,8'h0C,8'h10,8'h14,8'h18,8'h1C,8'h1C,8'h80,8'h80,8'h80,8'h00,8'h00};
    chk_out(3'd0, 8'h00, "R1 outputs");
    chk_rd(9'h036, 16'h3FFE, "R1 mask");
    for (int s = 1; s <= 13; s++) chk_rd(9'(8'h14 + s - 1), {8'h00, rv[s]}, "R1 ctrl");
    chk_rd(9'h042, 16'h000F, "R1 wdog vec");
    chk_rd(9'h170, 16'h000F, "R1 uart0 vec");
    chk_rd(9'h1B0, 16'h000F, "R1 uart1 vec");
  endtask

  task automatic t_pending();
    irq_req = 13'h1005; // sources 13, 3, 1
    settle();
    chk_rd(9'h03A, 16'h200A, "R2 pending");
    chk_out(3'd0, 8'h00, "R3 all masked at reset");
    wr(9'h03A, 16'hFFFF);
    chk_rd(9'h03A, 16'h200A, "R2 write ignored");
    irq_req = '0;
    settle();
    chk_rd(9'h03A, 16'h0000, "R2 pending cleared");
  endtask

  task automatic t_mask();
    irq_req = one(7);
    settle();
    chk_out(3'd0, 8'h00, "R3 masked source");
    wr(9'h036, 16'h0000);
    settle();
    chk_out(3'd7, 8'h0F, "R3 unmasked source 7");
    wr(9'h036, 16'h0080);
    settle();
    chk_out(3'd0, 8'h00, "R3 bit 7 masks source 7");
    wr(9'h036, 16'h0000);
    irq_req = '0;
    settle();
  endtask

  task automatic t_priority();
    irq_req = one(2) | one(3) | one(5);
    settle();
    chk_out(3'd5, 8'h0F, "R4 level 5 beats 3 and 2");
    irq_req = one(2) | one(3);
    settle();
    chk_out(3'd3, 8'h0F, "R4 level 3 beats 2");
    wr(9'h016, 16'h0097); // source 3: level 5, priority 3, autovector
    irq_req = one(3) | one(5);
    settle();
    chk_out(3'd5, 8'd29, "R4 priority bits order within a level");
    irq_req = '0;
    settle();
  endtask

  task automatic t_tie();
    wr(9'h017, 16'h0013); // source 4: code 19, own vector path
    wr(9'h019, 16'h0093); // source 6: code 19, autovector
    irq_req = one(4) | one(6);
    settle();
    chk_out(3'd4, 8'h0F, "R5 tie goes to source 4");
    irq_req = one(6);
    settle();
    chk_out(3'd4, 8'd28, "R7 source 6 autovector 24+4");
    irq_req = '0;
    settle();
  endtask

  task automatic t_low();
    wr(9'h014, 16'h0003);
    irq_req = one(1);
    settle();
    chk_out(3'd0, 8'h00, "R6 code 3 suppressed");
    wr(9'h014, 16'h0004);
    settle();
    chk_out(3'd1, 8'h0F, "R6 code 4 presented");
    irq_req = one(9); // source 9 reset control 0x80: code 0
    settle();
    chk_out(3'd0, 8'h00, "R6 autovector source at level 0 suppressed");
    irq_req = '0;
    settle();
  endtask

  task automatic t_vectors();
    wr(9'h042, 16'h0040);
    wr(9'h170, 16'h0041);
    wr(9'h1B0, 16'h0042);
    chk_rd(9'h042, 16'h0040, "R8 wdog vec readback");
    irq_req = one(8);
    settle();
    chk_out(3'd7, 8'h40, "R8 source 8 watchdog vector");
    wr(9'h01B, 16'h009C);
    settle();
    chk_out(3'd7, 8'd31, "R7 source 8 autovector overrides");
    wr(9'h01F, 16'h0014);
    irq_req = one(12);
    settle();
    chk_out(3'd5, 8'h41, "R8 source 12 first serial vector");
    wr(9'h020, 16'h0018);
    irq_req = one(13);
    settle();
    chk_out(3'd6, 8'h42, "R8 source 13 second serial vector");
    wr(9'h01C, 16'h0088);
    irq_req = one(9);
    settle();
    chk_out(3'd2, 8'd26, "R7 source 9 autovector 24+2");
    irq_req = '0;
    settle();
  endtask

  task automatic t_timing();
    irq_req = one(5); // control 0x14: level 5
    @(negedge clk);
    chk_out(3'd0, 8'h00, "R9 one edge after request");
    @(negedge clk);
    chk_out(3'd5, 8'h0F, "R9 two edges after request");
    wr(9'h036, 16'h0020);
    chk_out(3'd5, 8'h0F, "R9 write edge only");
    @(negedge clk);
    chk_out(3'd0, 8'h00, "R9 mask seen one edge later");
    irq_req = '0;
    settle();
  endtask

  task automatic t_map();
    chk_rd(9'h000, 16'h0000, "R10 unmapped read");
    wr(9'h037, 16'hFFFF);
    chk_rd(9'h036, 16'h0020, "R10 unmapped write ignored");
    chk_rd(9'h020, 16'h0018, "R10 ctrl 13 at 0x20");
    chk_rd(9'h014, 16'h0004, "R10 ctrl 1 at 0x14");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pending();
    t_mask();
    t_priority();
    t_tie();
    t_low();
    t_vectors();
    t_timing();
    t_map();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, got no finish expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule